// File: doc/BRIEF.md
# SDRAM Refresh Scheduler

This block produces the periodic auto-refresh traffic for a four-bank SDRAM. An interval timer adds one owed refresh each time it expires. While at least one refresh is owed, the block raises a request toward the main command arbiter. When the arbiter grants the bus, the scheduler closes any open rows with a precharge-all command and waits the precharge time. It then issues every owed auto-refresh, keeping a full row-cycle gap after each one, and drops its request so the arbiter takes the bus back.

While the arbiter is busy, up to a set number of refreshes can be postponed. When that limit is reached, an urgent flag tells the arbiter to serve the scheduler first. All timing is given in picoseconds and converted to clock counts inside the block. The refresh interval rounds down, so refreshes are never late. The precharge time and the row-cycle time round up, so those gaps are never short.

Top module: `sdram_refresh_sched`

## Requirements
- R1: During and right after reset, `req` and `req_urgent` are low, `cs_n` is high and `a10` is low.
- R2: With `refresh_en` high, one refresh becomes owed every REFI = floor(REFI_PS/CLK_PS) cycles. The first request appears REFI clock edges after enable, and the second appears 2·REFI edges after enable even if the first was served in between.
- R3: While `refresh_en` is low, no new refresh becomes owed and the timer restarts. Refreshes already owed stay owed and are still served.
- R4: If any `banks_open` bit is set when a grant is accepted, the first command is precharge-all, one cycle after the edge that samples the grant. Precharge-all is `cs_n`=0, `ras_n`=0, `cas_n`=1, `we_n`=0, `a10`=1, `ba`=0.
- R5: The first auto-refresh after a precharge-all comes exactly TRP = ceil(TRP_PS/CLK_PS) cycles after it.
- R6: If no bank is open, the first command of the grant is auto-refresh, one cycle after the edge that samples the grant.
- R7: Auto-refresh is `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1. `cke` is high both in that cycle and in the cycle before it.
- R8: Back-to-back auto-refreshes are exactly TRC = ceil(TRC_PS/CLK_PS) cycles apart. The bus is released, with `req` low and `cs_n` high, exactly TRC cycles after the last one.
- R9: Every cycle the scheduler owns the bus without issuing a command carries a NOP (`cs_n`=0, `ras_n`=`cas_n`=`we_n`=1). No other command code ever appears.
- R10: Up to OWE_MAX refreshes accumulate while no grant is given, and one grant drains all of them. Intervals that expire while OWE_MAX refreshes are already owed are dropped.
- R11: `req_urgent` is high exactly while OWE_MAX refreshes are owed.
- R12: Whenever the scheduler does not own the bus, `cs_n` is high, including while it is still waiting for a grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_en | input | 1 | Enables the interval timer |
| banks_open | input | BANKS | One bit per bank with a row currently open |
| grant | input | 1 | Arbiter hands the command bus to the scheduler |
| req | output | 1 | Refresh owed or bus in use |
| req_urgent | output | 1 | Postponement limit reached |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| a10 | output | 1 | All-banks select for precharge |
| ba | output | $clog2(BANKS) | Bank address, held at zero |

## Verification
The assertions assume the arbiter raises `grant` only while `req` is high, holds it until the scheduler releases the bus, and does not change `banks_open` mid-sequence. The bench follows this pattern. Each scenario raises `grant` on a falling edge while a request is pending and watches every command until deselect returns. Only after that does it drop `grant`. The bench starts each scenario from reset, so the timer phase is known. It schedules each drain well inside one refresh interval, so no new tick lands during a drain and the expected refresh counts are exact.

// File: rtl/sdram_refresh_sched.sv
module sdram_refresh_sched #(
  parameter int CLK_PS  = 10000,
  parameter int REFI_PS = 15_625_000,
  parameter int TRP_PS  = 20000,
  parameter int TRC_PS  = 60000,
  parameter int OWE_MAX = 8,
  parameter int BANKS   = 4,
  localparam int BA_W   = $clog2(BANKS)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            refresh_en,
  input  logic [BANKS-1:0] banks_open,
  input  logic            grant,
  output logic            req,
  output logic            req_urgent,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            cke,
  output logic            a10,
  output logic [BA_W-1:0] ba
);

  localparam int REFI_CYC = REFI_PS / CLK_PS;
  localparam int TRP_CYC  = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRC_CYC  = (TRC_PS + CLK_PS - 1) / CLK_PS;
  localparam int TMR_W    = $clog2(REFI_CYC);
  localparam int OWE_W    = $clog2(OWE_MAX + 1);
  localparam int WAIT_MAX = (TRC_CYC > TRP_CYC) ? TRC_CYC : TRP_CYC;
  localparam int WAIT_W   = $clog2(WAIT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_WRP, S_REF, S_WRC} st_t;

  st_t               st, st_n;
  logic [WAIT_W-1:0] wcnt, wcnt_n;
  logic [TMR_W-1:0]  tmr;
  logic [OWE_W-1:0]  owed, owed_n;
  logic              cke_q;
  logic              tick, dec;

  assign tick = refresh_en && (tmr == '0);
  assign dec  = (st == S_REF);

  always_ff @(posedge clk) begin
    if (!rst_n || !refresh_en) tmr <= TMR_W'(REFI_CYC - 1);
    else if (tmr == '0)        tmr <= TMR_W'(REFI_CYC - 1);
    else                       tmr <= tmr - 1'b1;
  end

  always_comb begin
    owed_n = owed;
    if (tick && !dec) begin
      if (owed != OWE_W'(OWE_MAX)) owed_n = owed + 1'b1;
    end else if (!tick && dec) begin
      owed_n = owed - 1'b1;
    end
  end

  always_comb begin
    st_n   = st;
    wcnt_n = wcnt;
    case (st)
      S_IDLE: if (grant && owed != '0) st_n = (|banks_open) ? S_PRE : S_REF;
      S_PRE: begin
        if (TRP_CYC > 1) begin
          st_n   = S_WRP;
          wcnt_n = WAIT_W'(TRP_CYC - 2);
        end else st_n = S_REF;
      end
      S_WRP: begin
        if (wcnt == '0) st_n = S_REF;
        else            wcnt_n = wcnt - 1'b1;
      end
      S_REF: begin
        if (TRC_CYC > 1) begin
          st_n   = S_WRC;
          wcnt_n = WAIT_W'(TRC_CYC - 2);
        end else st_n = (grant && owed_n != '0) ? S_REF : S_IDLE;
      end
      S_WRC: begin
        if (wcnt == '0) st_n = (grant && owed_n != '0) ? S_REF : S_IDLE;
        else            wcnt_n = wcnt - 1'b1;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      wcnt  <= '0;
      owed  <= '0;
      cke_q <= 1'b0;
    end else begin
      st    <= st_n;
      wcnt  <= wcnt_n;
      owed  <= owed_n;
      cke_q <= 1'b1;
    end
  end

  assign req        = (st != S_IDLE) || (owed != '0);
  assign req_urgent = (owed == OWE_W'(OWE_MAX));
  assign cs_n       = (st == S_IDLE);
  assign ras_n      = !(st == S_PRE || st == S_REF);
  assign cas_n      = (st != S_REF);
  assign we_n       = (st != S_PRE);
  assign a10        = (st == S_PRE);
  assign cke        = cke_q;
  assign ba         = '0;

endmodule

// File: rtl/sdram_refresh_sched_chk.sv
module sdram_refresh_sched_chk #(
  parameter int CLK_PS = 10000,
  parameter int TRP_PS = 20000,
  parameter int TRC_PS = 60000
)(
  input logic clk,
  input logic rst_n,
  input logic grant,
  input logic req,
  input logic req_urgent,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic cke,
  input logic a10
);
  localparam int TRP_CYC = (TRP_PS + CLK_PS - 1) / CLK_PS;
  localparam int TRC_CYC = (TRC_PS + CLK_PS - 1) / CLK_PS;

  logic is_pre, is_ref, is_nop;
  logic [15:0] since_pre, since_ref;

  assign is_pre = !cs_n && !ras_n &&  cas_n && !we_n;
  assign is_ref = !cs_n && !ras_n && !cas_n &&  we_n;
  assign is_nop = !cs_n &&  ras_n &&  cas_n &&  we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= 16'hFFFF;
      since_ref <= 16'hFFFF;
    end else begin
      since_pre <= is_pre ? 16'd1 : (since_pre == 16'hFFFF ? since_pre : since_pre + 1'b1);
      since_ref <= is_ref ? 16'd1 : (since_ref == 16'hFFFF ? since_ref : since_ref + 1'b1);
    end
  end

  // R9
  cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> (is_pre || is_ref || is_nop));

  // R4
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> a10);

  // R4
  grant_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cs_n) && !cs_n) |-> $past(grant));

  // R5
  trp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (since_pre >= 16'(TRP_CYC)));

  // R8
  trc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref || is_pre) |-> (since_ref >= 16'(TRC_CYC)));

  // R7
  ref_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (cke && $past(cke)));

  // R11
  urgent_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_urgent |-> req);

  // R12
  idle_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> cs_n);

endmodule

bind sdram_refresh_sched sdram_refresh_sched_chk #(
  .CLK_PS(CLK_PS), .TRP_PS(TRP_PS), .TRC_PS(TRC_PS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .req(req), .req_urgent(req_urgent),
  .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cke(cke), .a10(a10)
);

// File: tb/sdram_refresh_sched_bench.sv
`timescale 1ns/1ps
module sdram_refresh_sched_bench;
  localparam int CLK_PS  = 10000;
  localparam int REFI_PS = 1_000_000;
  localparam int TRP_PS  = 15000;
  localparam int TRC_PS  = 60000;
  localparam int OWE_MAX = 8;
  localparam int REFI = 100;
  localparam int TRP  = 2;
  localparam int TRC  = 6;
  localparam int C_DES = 0, C_NOP = 1, C_PRE = 2, C_REF = 3, C_BAD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic refresh_en = 1'b0;
  logic [3:0] banks_open = '0;
  logic grant = 1'b0;
  logic req, req_urgent, cs_n, ras_n, cas_n, we_n, cke, a10;
  logic [1:0] ba;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sdram_refresh_sched #(
    .CLK_PS(CLK_PS), .REFI_PS(REFI_PS), .TRP_PS(TRP_PS), .TRC_PS(TRC_PS),
    .OWE_MAX(OWE_MAX), .BANKS(4)
  ) u_sdram_refresh_sched (
    .clk(clk), .rst_n(rst_n), .refresh_en(refresh_en), .banks_open(banks_open),
    .grant(grant), .req(req), .req_urgent(req_urgent), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .a10(a10), .ba(ba)
  );

  task automatic chk(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic int decode();
    if (cs_n) return C_DES;
    if (ras_n && cas_n && we_n) return C_NOP;
    if (!ras_n && cas_n && !we_n) return C_PRE;
    if (!ras_n && !cas_n && we_n) return C_REF;
    return C_BAD;
  endfunction

  task automatic do_reset(input bit en);
    @(negedge clk);
    rst_n = 1'b0; refresh_en = en; grant = 1'b0; banks_open = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run_grant(input int exp_refs, input bit exp_pre, output int used);
    int nref = 0, nnop = 0, pre_cyc = 0, last_ref = 0, c;
    logic prev_cke;
    prev_cke = cke;
    used = 0;
    grant = 1'b1;
    for (int cyc = 1; cyc <= 400; cyc++) begin
      @(negedge clk);
      used = cyc;
      c = decode();
      if (cyc == 1) chk(exp_pre ? "R4" : "R6", "first command", c, exp_pre ? C_PRE : C_REF);
      if (c == C_PRE) begin
        pre_cyc = cyc;
        chk("R4", "precharge a10", int'(a10), 1);
        chk("R4", "precharge ba", int'(ba), 0);
      end else if (c == C_REF) begin
        nref++;
        if (exp_pre && nref == 1) chk("R5", "precharge to refresh gap", cyc - pre_cyc, TRP);
        if (nref > 1) chk("R8", "refresh to refresh gap", cyc - last_ref, TRC);
        chk("R7", "cke at refresh", int'(cke), 1);
        chk("R7", "cke before refresh", int'(prev_cke), 1);
        last_ref = cyc;
      end else if (c == C_NOP) begin
        nnop++;
      end else if (c == C_BAD) begin
        chk("R9", "illegal command code", c, C_NOP);
      end else begin
        chk("R8", "release after last refresh", cyc - last_ref, TRC);
        chk("R12", "req at release", int'(req), 0);
        break;
      end
      prev_cke = cke;
    end
    grant = 1'b0;
    chk("R10", "refreshes issued", nref, exp_refs);
    chk("R9", "wait cycles with NOP", nnop, (exp_pre ? TRP - 1 : 0) + exp_refs * (TRC - 1));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", "cs_n in reset", int'(cs_n), 1);
    do_reset(0);
    @(negedge clk);
    chk("R1", "req after reset", int'(req), 0);
    chk("R1", "urgent after reset", int'(req_urgent), 0);
    chk("R1", "cs_n after reset", int'(cs_n), 1);
    chk("R1", "a10 after reset", int'(a10), 0);
  endtask

  task automatic t_interval();
    int k = 0, used, k2 = 0;
    do_reset(1);
    while (!req && k < 3 * REFI) begin @(negedge clk); k++; end
    chk("R2", "first request edge", k, REFI);
    banks_open = '0;
    run_grant(1, 0, used);
    while (!req && k2 < 3 * REFI) begin @(negedge clk); k2++; end
    chk("R2", "second request edge", k + used + k2, 2 * REFI);
  endtask

  task automatic t_precharge();
    int used;
    do_reset(1);
    repeat (REFI + 2) @(negedge clk);
    banks_open = 4'b0110;
    run_grant(1, 1, used);
  endtask

  task automatic t_postpone();
    int used;
    do_reset(1);
    repeat (3 * REFI + 5) @(negedge clk);
    chk("R11", "urgent with three owed", int'(req_urgent), 0);
    chk("R12", "cs_n while waiting for grant", int'(cs_n), 1);
    banks_open = 4'b1000;
    run_grant(3, 1, used);
  endtask

  task automatic t_saturate();
    int used;
    do_reset(1);
    repeat (7 * REFI + 5) @(negedge clk);
    chk("R11", "urgent with seven owed", int'(req_urgent), 0);
    repeat (REFI) @(negedge clk);
    chk("R11", "urgent with limit owed", int'(req_urgent), 1);
    repeat (2 * REFI) @(negedge clk);
    chk("R11", "urgent past limit", int'(req_urgent), 1);
    run_grant(OWE_MAX, 0, used);
    chk("R11", "urgent after drain", int'(req_urgent), 0);
  endtask

  task automatic t_disable();
    int hits = 0, used;
    do_reset(0);
    for (int i = 0; i < 3 * REFI; i++) begin
      @(negedge clk);
      if (req) hits++;
    end
    chk("R3", "request cycles while disabled", hits, 0);
    refresh_en = 1'b1;
    repeat (REFI + 2) @(negedge clk);
    refresh_en = 1'b0;
    repeat (2 * REFI) @(negedge clk);
    chk("R3", "owed refresh kept while disabled", int'(req), 1);
    run_grant(1, 0, used);
    @(negedge clk);
    chk("R3", "req after draining while disabled", int'(req), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_interval();
    t_precharge();
    t_postpone();
    t_saturate();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule